// File: doc/BRIEF.md
# Accumulator CPU Fetch-Execute Sequencer

This block is a small single-accumulator processor. It runs each instruction as a fixed series of register transfers among a program counter, a memory address register, a memory buffer register, an instruction register and the accumulator. Each step performs exactly one transfer. Instructions are 32-bit words. The upper byte selects the operation and the lower 24 bits give a byte address for the operand.

The processor supports three operations: load into the accumulator, add to the accumulator, and store the accumulator. Program and data share a word array inside the block. A testbench or loader fills that array through a write port. The core begins fetching at the address presented on `start_addr` when reset is released. It stops at the first opcode it does not recognise. Debug outputs show the program counter, the accumulator and the instruction register at every cycle.

Top module: `acc_cpu`

## Requirements
- R1: While reset is active, the program counter takes the value of `start_addr`, and the accumulator, instruction, address and buffer registers read zero. `halt` is low.
- R2: Fetch uses three steps: the address register is loaded from the program counter, the buffer is loaded from memory, then the instruction register is loaded from the buffer. The instruction register and the program counter (which advances by 4) both change on the third clock edge of an instruction.
- R3: The opcode is bits 31:24 of the instruction and the operand byte address is bits 23:0. Memory words are selected by the byte address shifted right by 2, so bits 1:0 of an address are ignored.
- R4: Opcode 0x02 copies the addressed memory word into the accumulator. The accumulator changes on no other cycle except the last step of a load or an add.
- R5: Opcode 0x03 adds the addressed memory word to the accumulator, modulo 2^32.
- R6: Opcode 0x01 writes the accumulator to the addressed memory word and leaves the accumulator unchanged.
- R7: A defined instruction takes exactly six clock cycles. After that, the next fetch starts from the advanced program counter.
- R8: An undefined opcode (anything except 0x01, 0x02 or 0x03, including 0x00) raises `halt` on the fourth clock edge of that instruction. From then on, `halt`, the program counter, the accumulator and the instruction register hold their values until reset.
- R9: When `ld_en` is high, `ld_data` is written to the word selected by `ld_addr` on the rising clock edge. The memory keeps its contents through reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_addr | input | 24 | Byte address of the first instruction |
| ld_en | input | 1 | Loader write enable |
| ld_addr | input | 24 | Loader byte address |
| ld_data | input | 32 | Loader write data |
| halt | output | 1 | High after an undefined opcode |
| dbg_pc | output | 24 | Program counter |
| dbg_ac | output | 32 | Accumulator |
| dbg_ir | output | 32 | Instruction register |

## Verification
A step sequencer that skips or repeats a state shifts every later instruction boundary. The instruction register would then change on the wrong edge within one instruction, and the program counter would be off by 4 at the next six-cycle sample. An address register fed from the wrong source, or a wrong word index, makes a later load return the wrong word, which shows on `dbg_ac` at the end of that instruction. A store that failed stays hidden until a later load reads the same word back. A halt state that leaks shows as movement on `dbg_pc` or `dbg_ir` within one cycle of `halt` rising.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

  localparam int DATA_W = 32;
  localparam int OP_W   = 8;
  localparam int ADDR_W = DATA_W - OP_W;

  localparam logic [OP_W-1:0] OP_STORE = 8'h01;
  localparam logic [OP_W-1:0] OP_LOAD  = 8'h02;
  localparam logic [OP_W-1:0] OP_ADD   = 8'h03;

  typedef enum logic [2:0] {
    ST_F_MAR = 3'd0,
    ST_F_MBR = 3'd1,
    ST_F_IR  = 3'd2,
    ST_X_MAR = 3'd3,
    ST_X_MBR = 3'd4,
    ST_X_FIN = 3'd5,
    ST_HALT  = 3'd6
  } step_t;

  typedef struct packed {
    logic mar_pc;
    logic mar_ir;
    logic mbr_mem;
    logic mbr_ac;
    logic ir_ld;
    logic pc_inc;
    logic ac_mbr;
    logic ac_sum;
    logic mem_we;
  } ctl_t;

  function automatic logic op_known(input logic [OP_W-1:0] op);
    return (op == OP_STORE) || (op == OP_LOAD) || (op == OP_ADD);
  endfunction

  function automatic logic [DATA_W-1:0] acc_sum(input logic [DATA_W-1:0] a,
                                                input logic [DATA_W-1:0] b);
    return a + b;
  endfunction

  function automatic logic [ADDR_W-1:0] pc_next(input logic [ADDR_W-1:0] pc);
    return pc + ADDR_W'(4);
  endfunction

endpackage

// File: rtl/acc_mem.sv
module acc_mem #(
  parameter int ADDR_W    = 24,
  parameter int DATA_W    = 32,
  parameter int MEM_WORDS = 256
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_data,
  input  logic              ld_en,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [DATA_W-1:0] ld_data
);
  localparam int IDX_W = $clog2(MEM_WORDS);

  logic [DATA_W-1:0] words [MEM_WORDS];

  logic [IDX_W-1:0] rd_idx, cpu_idx, ld_idx;
  assign rd_idx  = rd_addr[IDX_W+1:2];
  assign cpu_idx = cpu_addr[IDX_W+1:2];
  assign ld_idx  = ld_addr[IDX_W+1:2];

  logic unused_bits;
  assign unused_bits = ^{rd_addr[ADDR_W-1:IDX_W+2], rd_addr[1:0],
                         cpu_addr[ADDR_W-1:IDX_W+2], cpu_addr[1:0],
                         ld_addr[ADDR_W-1:IDX_W+2], ld_addr[1:0]};

  assign rd_data = words[rd_idx];

  always_ff @(posedge clk) begin
    if (cpu_we)
      words[cpu_idx] <= cpu_data;
    else if (ld_en)
      words[ld_idx] <= ld_data;
  end

endmodule

// File: rtl/acc_seq.sv
module acc_seq
  import acc_cpu_pkg::*;
#(
  parameter int OPW = OP_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [OPW-1:0] op,
  output ctl_t           ctl,
  output logic           halted
);
  step_t step, step_nx;

  always_comb begin
    step_nx = step;
    case (step)
      ST_F_MAR: step_nx = ST_F_MBR;
      ST_F_MBR: step_nx = ST_F_IR;
      ST_F_IR:  step_nx = ST_X_MAR;
      ST_X_MAR: step_nx = op_known(op) ? ST_X_MBR : ST_HALT;
      ST_X_MBR: step_nx = ST_X_FIN;
      ST_X_FIN: step_nx = ST_F_MAR;
      default:  step_nx = ST_HALT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) step <= ST_F_MAR;
    else        step <= step_nx;
  end

  always_comb begin
    ctl = '0;
    case (step)
      ST_F_MAR: ctl.mar_pc = 1'b1;
      ST_F_MBR: ctl.mbr_mem = 1'b1;
      ST_F_IR: begin
        ctl.ir_ld  = 1'b1;
        ctl.pc_inc = 1'b1;
      end
      ST_X_MAR: ctl.mar_ir = op_known(op);
      ST_X_MBR: begin
        ctl.mbr_ac  = (op == OP_STORE);
        ctl.mbr_mem = (op != OP_STORE);
      end
      ST_X_FIN: begin
        ctl.ac_mbr = (op == OP_LOAD);
        ctl.ac_sum = (op == OP_ADD);
        ctl.mem_we = (op == OP_STORE);
      end
      default: ctl = '0;
    endcase
  end

  assign halted = (step == ST_HALT);

  // R2
  ir_after_mbr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.ir_ld |-> $past(ctl.mbr_mem));

  // R8
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);

endmodule

// File: rtl/acc_dpath.sv
module acc_dpath
  import acc_cpu_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] start_addr,
  input  ctl_t          ctl,
  input  logic [DW-1:0] mem_rd,
  output logic [AW-1:0] pc,
  output logic [AW-1:0] mar,
  output logic [DW-1:0] mbr,
  output logic [DW-1:0] ir,
  output logic [DW-1:0] ac,
  output logic          mem_we
);
  logic ev_ac_write;
  assign ev_ac_write = ctl.ac_mbr | ctl.ac_sum;
  assign mem_we      = ctl.mem_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc  <= start_addr;
      mar <= '0;
      mbr <= '0;
      ir  <= '0;
      ac  <= '0;
    end else begin
      if (ctl.mar_pc)       mar <= pc;
      else if (ctl.mar_ir)  mar <= ir[AW-1:0];
      if (ctl.mbr_mem)      mbr <= mem_rd;
      else if (ctl.mbr_ac)  mbr <= ac;
      if (ctl.ir_ld)        ir  <= mbr;
      if (ctl.pc_inc)       pc  <= pc_next(pc);
      if (ctl.ac_mbr)       ac  <= mbr;
      else if (ctl.ac_sum)  ac  <= acc_sum(mbr, ac);
    end
  end

  // R2
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.pc_inc |=> (pc == $past(pc) + AW'(4)));

  // R6
  store_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mbr == ac));

  // R6
  store_keeps_ac_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> $stable(ac));

  // R4
  ac_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_ac_write |=> $stable(ac));

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_cpu_pkg::*;
#(
  parameter int MEM_WORDS = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              ld_en,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [DATA_W-1:0] ld_data,
  output logic              halt,
  output logic [ADDR_W-1:0] dbg_pc,
  output logic [DATA_W-1:0] dbg_ac,
  output logic [DATA_W-1:0] dbg_ir
);
  ctl_t              ctl;
  logic [ADDR_W-1:0] pc, mar;
  logic [DATA_W-1:0] mbr, ir, ac, mem_rd;
  logic              mem_we;

  acc_seq #(.OPW(OP_W)) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .op     (ir[DATA_W-1:ADDR_W]),
    .ctl    (ctl),
    .halted (halt)
  );

  acc_dpath #(.AW(ADDR_W), .DW(DATA_W)) u_dpath (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_addr (start_addr),
    .ctl        (ctl),
    .mem_rd     (mem_rd),
    .pc         (pc),
    .mar        (mar),
    .mbr        (mbr),
    .ir         (ir),
    .ac         (ac),
    .mem_we     (mem_we)
  );

  acc_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MEM_WORDS(MEM_WORDS)) u_mem (
    .clk      (clk),
    .rd_addr  (mar),
    .rd_data  (mem_rd),
    .cpu_we   (mem_we),
    .cpu_addr (mar),
    .cpu_data (mbr),
    .ld_en    (ld_en),
    .ld_addr  (ld_addr),
    .ld_data  (ld_data)
  );

  assign dbg_pc = pc;
  assign dbg_ac = ac;
  assign dbg_ir = ir;

  // R8
  halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> (halt && $stable(dbg_pc) && $stable(dbg_ac) && $stable(dbg_ir)));

  // R7
  one_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctl.ir_ld, ctl.ac_mbr | ctl.ac_sum, mem_we}));

endmodule

// File: tb/acc_cpu_tb.sv
module acc_cpu_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] start_addr = 24'h40;
  logic        ld_en = 1'b0;
  logic [23:0] ld_addr = '0;
  logic [31:0] ld_data = '0;
  logic        halt;
  logic [23:0] dbg_pc;
  logic [31:0] dbg_ac, dbg_ir;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [23:0] pc;
    logic [31:0] ir;
    logic [31:0] ac;
    string       tag;
  } exp_t;

  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_cpu u_dut (
    .clk(clk), .rst_n(rst_n), .start_addr(start_addr),
    .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
    .halt(halt), .dbg_pc(dbg_pc), .dbg_ac(dbg_ac), .dbg_ir(dbg_ir)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic poke(input logic [23:0] a, input logic [31:0] d);
    @(negedge clk);
    ld_en = 1'b1; ld_addr = a; ld_data = d;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic push(input logic [23:0] pc, input logic [31:0] ir,
                      input logic [31:0] ac, input string tag);
    exp_t e;
    e.pc = pc; e.ir = ir; e.ac = ac; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic monitor(input int n);
    for (int i = 0; i < n; i++) begin
      exp_t e;
      repeat (6) @(negedge clk);
      e = sb.pop_front();
      check(dbg_pc == e.pc, {e.tag, " pc"}, 32'(dbg_pc), 32'(e.pc));
      check(dbg_ir == e.ir, {e.tag, " ir"}, dbg_ir, e.ir);
      check(dbg_ac == e.ac, {e.tag, " ac"}, dbg_ac, e.ac);
    end
  endtask

  initial begin
    // R9 preload, program 1 at 0x40, data at 0xE0..
    poke(24'hE0, 32'h16);
    poke(24'hE4, 32'h9E);
    poke(24'hEC, 32'hFFFF_FFF0);
    poke(24'hF0, 32'h25);
    poke(24'h40, 32'h0200_00E0);
    poke(24'h44, 32'h0300_00E4);
    poke(24'h48, 32'h0100_00E8);
    poke(24'h4C, 32'h0200_00EC);
    poke(24'h50, 32'h0300_00F0);
    poke(24'h54, 32'h0200_00EA);
    poke(24'h58, 32'h0100_00F4);
    poke(24'h5C, 32'h0300_00F4);
    poke(24'h60, 32'h0700_0000);
    @(negedge clk);
    // R1 reset state
    check(dbg_pc == 24'h40, "R1 pc", 32'(dbg_pc), 32'h40);
    check(dbg_ac == 0, "R1 ac", dbg_ac, 0);
    check(dbg_ir == 0, "R1 ir", dbg_ir, 0);
    check(halt == 1'b0, "R1 halt", 32'(halt), 0);
    fork
      begin
        push(24'h44, 32'h0200_00E0, 32'h16,        "R4 load");
        push(24'h48, 32'h0300_00E4, 32'hB4,        "R5 add");
        push(24'h4C, 32'h0100_00E8, 32'hB4,        "R6 store keeps ac");
        push(24'h50, 32'h0200_00EC, 32'hFFFF_FFF0, "R4 load big");
        push(24'h54, 32'h0300_00F0, 32'h15,        "R5 wrap");
        push(24'h58, 32'h0200_00EA, 32'hB4,        "R3 R6 unaligned readback");
        push(24'h5C, 32'h0100_00F4, 32'hB4,        "R7 store");
        push(24'h60, 32'h0300_00F4, 32'h168,       "R6 add stored");
      end
      begin
        rst_n = 1'b1;
        monitor(8);
      end
    join
    repeat (3) @(negedge clk);
    check(dbg_ir == 32'h0700_0000, "R8 bad op fetched", dbg_ir, 32'h0700_0000);
    check(halt == 1'b0, "R8 halt not before 4th edge", 32'(halt), 0);
    @(negedge clk);
    check(halt == 1'b1, "R8 halt on 4th edge", 32'(halt), 1);
    repeat (20) @(negedge clk);
    check(halt == 1'b1, "R8 halt held", 32'(halt), 1);
    check(dbg_pc == 24'h64, "R8 pc frozen", 32'(dbg_pc), 32'h64);
    check(dbg_ac == 32'h168, "R8 ac frozen", dbg_ac, 32'h168);
    check(dbg_ir == 32'h0700_0000, "R8 ir frozen", dbg_ir, 32'h0700_0000);

    // Run 2: new start address
    rst_n = 1'b0;
    start_addr = 24'h80;
    poke(24'h80, 32'h0300_00E0);
    poke(24'h84, 32'h0000_0000);
    @(negedge clk);
    check(dbg_pc == 24'h80, "R1 pc from start_addr", 32'(dbg_pc), 32'h80);
    check(dbg_ac == 0, "R1 ac cleared", dbg_ac, 0);
    check(halt == 1'b0, "R1 halt cleared", 32'(halt), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(dbg_ir == 0, "R2 ir before 3rd edge", dbg_ir, 0);
    check(dbg_pc == 24'h80, "R2 pc before 3rd edge", 32'(dbg_pc), 32'h80);
    @(negedge clk);
    check(dbg_ir == 32'h0300_00E0, "R2 ir on 3rd edge", dbg_ir, 32'h0300_00E0);
    check(dbg_pc == 24'h84, "R2 pc on 3rd edge", 32'(dbg_pc), 32'h84);
    repeat (3) @(negedge clk);
    check(dbg_ac == 32'h16, "R5 add from cleared ac", dbg_ac, 32'h16);
    repeat (3) @(negedge clk);
    check(dbg_ir == 0 && dbg_pc == 24'h88, "R7 next fetch", dbg_ir, 0);
    check(halt == 1'b0, "R8 no early halt", 32'(halt), 0);
    @(negedge clk);
    check(halt == 1'b1, "R8 opcode 00 halts", 32'(halt), 1);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule